// File: doc/BRIEF.md
# Memory Ordering Replay Trap Detector

This block watches memory operations as an out-of-order core issues them. It keeps a small window of operations that have issued but not yet retired. Each new operation is compared against that window to find ordering hazards that force a replay. A replay is a pipeline flush that restarts execution at a given instruction, much like recovery from a branch misprediction, and it needs no software handler.

Each issuing operation carries an age tag, a byte address, an access size and a load/store flag. The age tag is a program-order index with an extra wrap bit above it. Two side inputs also feed the window. One marks a tracked load as an outstanding cache miss, and a second clears that mark when the miss resolves. The other is an external write snoop from another agent.

The block recognises four kinds of hazard. When it finds one, it raises a one-cycle trap with the kind and the restart tag, and it empties its window. The flush itself, the cache lookup and store-to-load forwarding belong to neighbouring logic.

Top module: `rtrap_detector`

## Requirements
- R1: After reset the window is empty, no trap is reported, and a first issued operation never traps.
- R2: A store that issues while a younger tracked load overlaps it raises a trap of kind 0, restarting at that load's tag.
- R3: A load that overlaps an older tracked store of a different size raises a trap of kind 1, restarting at the issuing load. An older store of the same size causes no trap.
- R4: A load that issues while a younger overlapping tracked load has seen a snoop raises a trap of kind 2, restarting at the younger load. Without a snoop there is no trap.
- R5: A load that overlaps an older tracked load marked as an outstanding miss raises a trap of kind 3, restarting at the issuing load. Once the miss mark is cleared there is no trap.
- R6: Accesses are naturally aligned, with size code 0/1/2/3 meaning 1/2/4/8 bytes and the address bits below the size ignored. Two accesses overlap when their byte ranges share a byte.
- R7: When several hazards hit in one cycle, the oldest restart tag wins. Ties go to the lower kind code (0 first, 3 last).
- R8: The trap outputs are registered and appear in the cycle after the issuing cycle. The kind and tag read zero when no trap is reported.
- R9: A trap clears every tracked entry, and the operation that caused it is not entered into the window.
- R10: A retire carrying a tracked tag removes that entry, so it no longer causes any trap.
- R11: Age order uses the top tag bit as a wrap bit. A tag whose wrap bit differs from another's is younger when its lower bits are smaller.
- R12: A snoop marks every tracked load that lies in the same aligned block of 2^SNOOP_LG bytes (8 by default) as the snoop address. Loads outside that block are not marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A memory operation issues this cycle |
| iss_tag | input | TAG_W | Age tag of the issuing operation (wrap bit on top) |
| iss_addr | input | ADDR_W | Byte address of the issuing operation |
| iss_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 quad |
| iss_store | input | 1 | 1 for store, 0 for load |
| retire_valid | input | 1 | Remove a tracked entry |
| retire_tag | input | TAG_W | Tag of the entry to remove |
| miss_set_valid | input | 1 | Mark a tracked load as an outstanding miss |
| miss_set_tag | input | TAG_W | Tag of the load that missed |
| miss_clr_valid | input | 1 | Clear the outstanding-miss mark |
| miss_clr_tag | input | TAG_W | Tag of the load whose miss resolved |
| snoop_valid | input | 1 | An external agent writes memory |
| snoop_addr | input | ADDR_W | Address of the external write |
| trap_valid | output | 1 | Replay trap strobe |
| trap_kind | output | 2 | 0 store/load, 1 size mismatch, 2 load/load, 3 load after miss |
| trap_tag | output | TAG_W | Tag of the instruction to restart from |

## Verification
The hardest case to reach from the ports is two or more hazard kinds hitting in the same cycle, because each kind needs its own prior state. The load/load kind needs a younger load already issued and then snooped. The load-after-miss kind needs an older load with a pending miss mark. A size mismatch needs a store of a different width. Directed sequences build those states one cycle at a time and then issue a single load that hits several at once, both with equal and with unequal restart tags. They also issue ages on both sides of a tag wrap. A long random phase then permutes issue order inside small program-order blocks over a tight address range, and a behavioural model that counts ages with unbounded integers follows it on every clock.

// File: rtl/rtrap_pkg.sv
package rtrap_pkg;

   localparam int NUM_KINDS = 4;

   typedef enum logic [1:0] {
      TK_ST_LD = 2'd0,
      TK_SIZE  = 2'd1,
      TK_LD_LD = 2'd2,
      TK_MISS  = 2'd3
   } trap_kind_e;

   // restart lands on the tracked entry rather than on the issuing op
   function automatic bit restart_at_entry(input int k);
      return (k == int'(TK_ST_LD)) || (k == int'(TK_LD_LD));
   endfunction

   // a is older than b, tags of width w with wrap bit at w-1
   function automatic logic is_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
      logic [31:0] m;
      m = (32'd1 << (w - 1)) - 32'd1;
      if (a[w-1] == b[w-1]) return (a & m) < (b & m);
      else                  return (a & m) > (b & m);
   endfunction

   // naturally aligned ranges share a byte
   function automatic logic ranges_meet(input logic [31:0] a, input logic [1:0] sa,
                                        input logic [31:0] b, input logic [1:0] sb);
      logic [1:0] big;
      big = (sa > sb) ? sa : sb;
      return ((a ^ b) >> big) == 32'd0;
   endfunction

endpackage

// File: rtl/rtrap_slot.sv
module rtrap_slot
   import rtrap_pkg::*;
#(
   parameter int TAG_W    = 5,
   parameter int ADDR_W   = 16,
   parameter int SNOOP_LG = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_i,
   input  logic                 alloc_i,
   input  logic                 retire_v_i,
   input  logic [TAG_W-1:0]     retire_tag_i,
   input  logic                 mset_v_i,
   input  logic [TAG_W-1:0]     mset_tag_i,
   input  logic                 mclr_v_i,
   input  logic [TAG_W-1:0]     mclr_tag_i,
   input  logic                 snp_v_i,
   input  logic [ADDR_W-1:0]    snp_addr_i,
   input  logic                 iss_v_i,
   input  logic [TAG_W-1:0]     iss_tag_i,
   input  logic [ADDR_W-1:0]    iss_addr_i,
   input  logic [1:0]           iss_sz_i,
   input  logic                 iss_st_i,
   output logic                 occ_o,
   output logic [TAG_W-1:0]     tag_o,
   output logic [NUM_KINDS-1:0] hit_o
);

   logic              occ_q, st_q, miss_q, snp_q;
   logic [TAG_W-1:0]  tag_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        sz_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         occ_q  <= 1'b0;
         miss_q <= 1'b0;
         snp_q  <= 1'b0;
         st_q   <= 1'b0;
         tag_q  <= '0;
         addr_q <= '0;
         sz_q   <= '0;
      end else if (alloc_i) begin
         occ_q  <= 1'b1;
         tag_q  <= iss_tag_i;
         addr_q <= iss_addr_i;
         sz_q   <= iss_sz_i;
         st_q   <= iss_st_i;
         miss_q <= 1'b0;
         snp_q  <= 1'b0;
      end else if (occ_q) begin
         if (retire_v_i && retire_tag_i == tag_q) occ_q  <= 1'b0;
         if (mset_v_i && mset_tag_i == tag_q)     miss_q <= 1'b1;
         if (mclr_v_i && mclr_tag_i == tag_q)     miss_q <= 1'b0;
         if (snp_v_i && !st_q && ((addr_q ^ snp_addr_i) >> SNOOP_LG) == '0)
            snp_q <= 1'b1;
      end
   end

   logic meet, mine_older, iss_older;
   always_comb begin
      meet       = occ_q && iss_v_i &&
                   ranges_meet(32'(iss_addr_i), iss_sz_i, 32'(addr_q), sz_q);
      mine_older = is_older(32'(tag_q), 32'(iss_tag_i), TAG_W);
      iss_older  = is_older(32'(iss_tag_i), 32'(tag_q), TAG_W);
   end

   assign hit_o[TK_ST_LD] = meet && iss_st_i && !st_q && iss_older;
   assign hit_o[TK_SIZE]  = meet && !iss_st_i && st_q && mine_older && (sz_q != iss_sz_i);
   assign hit_o[TK_LD_LD] = meet && !iss_st_i && !st_q && iss_older && snp_q;
   assign hit_o[TK_MISS]  = meet && !iss_st_i && !st_q && mine_older && miss_q;

   assign occ_o = occ_q;
   assign tag_o = tag_q;

endmodule

// File: rtl/rtrap_oldest.sv
module rtrap_oldest
   import rtrap_pkg::*;
#(
   parameter int N     = 8,
   parameter int TAG_W = 5
) (
   input  logic [N-1:0]     flags_i,
   input  logic [TAG_W-1:0] tags_i [N],
   output logic             any_o,
   output logic [TAG_W-1:0] tag_o
);

   always_comb begin
      any_o = 1'b0;
      tag_o = '0;
      for (int i = 0; i < N; i++) begin
         if (flags_i[i] && (!any_o || is_older(32'(tags_i[i]), 32'(tag_o), TAG_W))) begin
            any_o = 1'b1;
            tag_o = tags_i[i];
         end
      end
   end

endmodule

// File: rtl/rtrap_detector.sv
module rtrap_detector
   import rtrap_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int TAG_W    = 5,
   parameter int ADDR_W   = 16,
   parameter int SNOOP_LG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [1:0]        iss_size,
   input  logic              iss_store,
   input  logic              retire_valid,
   input  logic [TAG_W-1:0]  retire_tag,
   input  logic              miss_set_valid,
   input  logic [TAG_W-1:0]  miss_set_tag,
   input  logic              miss_clr_valid,
   input  logic [TAG_W-1:0]  miss_clr_tag,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              trap_valid,
   output logic [1:0]        trap_kind,
   output logic [TAG_W-1:0]  trap_tag
);

   localparam int AGE_SPAN = 2 ** (TAG_W - 1);

   if (TAG_W < 2 || TAG_W > 32) begin : g_bad_tag
      $error("rtrap_detector: TAG_W out of range");
   end
   if (DEPTH < 1 || DEPTH > AGE_SPAN) begin : g_bad_depth
      $error("rtrap_detector: DEPTH must fit in half the tag space");
   end
   if (SNOOP_LG < 3 || ADDR_W > 32 || ADDR_W <= SNOOP_LG) begin : g_bad_addr
      $error("rtrap_detector: snoop block must hold a quad access");
   end

   logic [DEPTH-1:0]     slot_occ;
   logic [TAG_W-1:0]     slot_tag  [DEPTH];
   logic [NUM_KINDS-1:0] slot_hit  [DEPTH];
   logic [DEPTH-1:0]     kind_hits [NUM_KINDS];
   logic [DEPTH-1:0]     alloc;
   logic [NUM_KINDS-1:0] cand_v;
   logic [TAG_W-1:0]     cand_tag  [NUM_KINDS];
   logic                 sel_v;
   logic [1:0]           sel_k;
   logic [TAG_W-1:0]     sel_tag;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rtrap_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .SNOOP_LG(SNOOP_LG)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush_i      (sel_v),
         .alloc_i      (alloc[i]),
         .retire_v_i   (retire_valid),
         .retire_tag_i (retire_tag),
         .mset_v_i     (miss_set_valid),
         .mset_tag_i   (miss_set_tag),
         .mclr_v_i     (miss_clr_valid),
         .mclr_tag_i   (miss_clr_tag),
         .snp_v_i      (snoop_valid),
         .snp_addr_i   (snoop_addr),
         .iss_v_i      (iss_valid),
         .iss_tag_i    (iss_tag),
         .iss_addr_i   (iss_addr),
         .iss_sz_i     (iss_size),
         .iss_st_i     (iss_store),
         .occ_o        (slot_occ[i]),
         .tag_o        (slot_tag[i]),
         .hit_o        (slot_hit[i])
      );
   end

   always_comb begin
      for (int k = 0; k < NUM_KINDS; k++)
         for (int i = 0; i < DEPTH; i++)
            kind_hits[k][i] = slot_hit[i][k];
   end

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      if (restart_at_entry(k)) begin : g_entry
         rtrap_oldest #(.N(DEPTH), .TAG_W(TAG_W)) u_old (
            .flags_i (kind_hits[k]),
            .tags_i  (slot_tag),
            .any_o   (cand_v[k]),
            .tag_o   (cand_tag[k])
         );
      end else begin : g_self
         assign cand_v[k]   = |kind_hits[k];
         assign cand_tag[k] = iss_tag;
      end
   end

   always_comb begin
      sel_v   = 1'b0;
      sel_k   = '0;
      sel_tag = '0;
      for (int k = 0; k < NUM_KINDS; k++) begin
         if (cand_v[k] && (!sel_v || is_older(32'(cand_tag[k]), 32'(sel_tag), TAG_W))) begin
            sel_v   = 1'b1;
            sel_k   = 2'(k);
            sel_tag = cand_tag[k];
         end
      end
   end

   always_comb begin
      logic taken;
      taken = 1'b0;
      alloc = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!slot_occ[i] && !taken && iss_valid && !sel_v) begin
            alloc[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_valid <= 1'b0;
         trap_kind  <= '0;
         trap_tag   <= '0;
      end else begin
         trap_valid <= sel_v;
         trap_kind  <= sel_v ? sel_k : 2'd0;
         trap_tag   <= sel_v ? sel_tag : '0;
      end
   end

endmodule

// File: rtl/rtrap_checker.sv
module rtrap_checker
   import rtrap_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TAG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic             iss_store,
   input logic [TAG_W-1:0] iss_tag,
   input logic             trap_valid,
   input logic [1:0]       trap_kind,
   input logic [TAG_W-1:0] trap_tag,
   input logic [DEPTH-1:0] occ
);

   assert_trap_follows_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $past(iss_valid));

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> occ == '0);

   assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> !trap_valid);

   assert_store_restarts_younger_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_kind == 2'd0) |->
         ($past(iss_store) && is_older(32'($past(iss_tag)), 32'(trap_tag), TAG_W)));

   assert_size_restarts_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_kind == 2'd1) |-> (!$past(iss_store) && trap_tag == $past(iss_tag)));

   assert_ldld_restarts_younger_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_kind == 2'd2) |->
         (!$past(iss_store) && is_older(32'($past(iss_tag)), 32'(trap_tag), TAG_W)));

   assert_miss_restarts_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_kind == 2'd3) |-> (!$past(iss_store) && trap_tag == $past(iss_tag)));

endmodule

bind rtrap_detector rtrap_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_valid  (iss_valid),
   .iss_store  (iss_store),
   .iss_tag    (iss_tag),
   .trap_valid (trap_valid),
   .trap_kind  (trap_kind),
   .trap_tag   (trap_tag),
   .occ        (slot_occ)
);

// File: tb/tb_rtrap_detector.sv
`timescale 1ns/1ps
module tb_rtrap_detector;

   localparam int DEPTH  = 8;
   localparam int TAG_W  = 5;
   localparam int ADDR_W = 16;
   localparam int TMASK  = (1 << TAG_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              iss_valid, iss_store, retire_valid, miss_set_valid, miss_clr_valid, snoop_valid;
   logic [TAG_W-1:0]  iss_tag, retire_tag, miss_set_tag, miss_clr_tag;
   logic [ADDR_W-1:0] iss_addr, snoop_addr;
   logic [1:0]        iss_size;
   logic              trap_valid;
   logic [1:0]        trap_kind;
   logic [TAG_W-1:0]  trap_tag;

   always #2 clk = ~clk;

   rtrap_detector #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_size(iss_size),
      .iss_store(iss_store), .retire_valid(retire_valid), .retire_tag(retire_tag),
      .miss_set_valid(miss_set_valid), .miss_set_tag(miss_set_tag),
      .miss_clr_valid(miss_clr_valid), .miss_clr_tag(miss_clr_tag),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_tag(trap_tag));

   typedef struct {int seq; int addr; int sz; bit st; bit miss; bit snp;} ment_t;
   ment_t mq[$];

   int total = 0, bad = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // stimulus for the next cycle
   bit g_iv, g_ist, g_rv, g_msv, g_mcv, g_sv;
   int g_iseq, g_iaddr, g_isz, g_rseq, g_msseq, g_mcseq, g_saddr;
   bit exp_v; int exp_k, exp_tag;

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic bit meets(input int a1, input int s1, input int a2, input int s2);
      return (a1 < a2 + (1 << s2)) && (a2 < a1 + (1 << s1));
   endfunction

   function automatic void model_step();
      int best, bk;
      best = 0; bk = -1;
      if (g_iv) foreach (mq[i]) begin
         if (meets(g_iaddr, g_isz, mq[i].addr, mq[i].sz)) begin
            for (int kk = 0; kk < 4; kk++) begin
               bit h; int rs;
               h = 0; rs = 0;
               case (kk)
                  0: if (g_ist && !mq[i].st && mq[i].seq > g_iseq) begin h = 1; rs = mq[i].seq; end
                  1: if (!g_ist && mq[i].st && mq[i].seq < g_iseq && mq[i].sz != g_isz) begin h = 1; rs = g_iseq; end
                  2: if (!g_ist && !mq[i].st && mq[i].seq > g_iseq && mq[i].snp) begin h = 1; rs = mq[i].seq; end
                  default: if (!g_ist && !mq[i].st && mq[i].seq < g_iseq && mq[i].miss) begin h = 1; rs = g_iseq; end
               endcase
               if (h && (bk < 0 || rs < best || (rs == best && kk < bk))) begin best = rs; bk = kk; end
            end
         end
      end
      exp_v   = (bk >= 0);
      exp_k   = exp_v ? bk : 0;
      exp_tag = exp_v ? (best & TMASK) : 0;
      if (exp_v) mq.delete();
      else begin
         for (int i = mq.size() - 1; i >= 0; i--)
            if (g_rv && mq[i].seq == g_rseq) mq.delete(i);
         foreach (mq[i]) begin
            if (g_msv && mq[i].seq == g_msseq) mq[i].miss = 1;
            if (g_mcv && mq[i].seq == g_mcseq) mq[i].miss = 0;
            if (g_sv && !mq[i].st && (mq[i].addr >> 3) == (g_saddr >> 3)) mq[i].snp = 1;
         end
         if (g_iv) mq.push_back('{g_iseq, g_iaddr, g_isz, g_ist, 1'b0, 1'b0});
      end
   endfunction

   task automatic tick();
      iss_valid      = g_iv;   iss_tag      = TAG_W'(g_iseq & TMASK);
      iss_addr       = ADDR_W'(g_iaddr); iss_size = 2'(g_isz); iss_store = g_ist;
      retire_valid   = g_rv;   retire_tag   = TAG_W'(g_rseq & TMASK);
      miss_set_valid = g_msv;  miss_set_tag = TAG_W'(g_msseq & TMASK);
      miss_clr_valid = g_mcv;  miss_clr_tag = TAG_W'(g_mcseq & TMASK);
      snoop_valid    = g_sv;   snoop_addr   = ADDR_W'(g_saddr);
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(trap_valid === exp_v, cur_req, "model trap_valid", int'(trap_valid), int'(exp_v));
      if (exp_v) begin
         check(int'(trap_kind) == exp_k, cur_req, "model trap_kind", int'(trap_kind), exp_k);
         check(int'(trap_tag) == exp_tag, cur_req, "model trap_tag", int'(trap_tag), exp_tag);
      end else begin
         check(trap_kind == 2'd0 && trap_tag == '0, "R8", "idle fields", int'(trap_tag), 0);
      end
      {g_iv, g_ist, g_rv, g_msv, g_mcv, g_sv} = '0;
   endtask

   task automatic issue(input int seq, input int addr, input int sz, input bit st);
      g_iv = 1; g_iseq = seq; g_iaddr = addr; g_isz = sz; g_ist = st;
      tick();
   endtask

   task automatic expect_trap(input bit v, input int k, input int tag, input string req);
      check(trap_valid === v, req, "trap_valid", int'(trap_valid), int'(v));
      if (v) begin
         check(int'(trap_kind) == k, req, "trap_kind", int'(trap_kind), k);
         check(int'(trap_tag) == tag, req, "trap_tag", int'(trap_tag), tag);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {g_iv, g_ist, g_rv, g_msv, g_mcv, g_sv} = '0;
      {iss_valid, iss_store, retire_valid, miss_set_valid, miss_clr_valid, snoop_valid} = '0;
      iss_tag = '0; retire_tag = '0; miss_set_tag = '0; miss_clr_tag = '0;
      iss_addr = '0; snoop_addr = '0; iss_size = '0;
      mq.delete();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int b, pos;
      int perm[4];
      do_reset();
      // R1: quiet after reset, first op never traps
      cur_req = "R1";
      expect_trap(0, 0, 0, "R1");
      issue(3, 'h00, 0, 1); expect_trap(0, 0, 0, "R1");

      // R2 store/load, then R9 flush drops window and causing store
      do_reset(); cur_req = "R2";
      issue(5, 'h10, 0, 0);
      issue(4, 'h10, 0, 1); expect_trap(1, 0, 5, "R2");
      cur_req = "R9";
      issue(6, 'h10, 1, 0); expect_trap(0, 0, 0, "R9");

      // R3 size mismatch, and same size no trap
      do_reset(); cur_req = "R3";
      issue(1, 'h21, 0, 1);
      issue(2, 'h20, 1, 0); expect_trap(1, 1, 2, "R3");
      do_reset();
      issue(1, 'h20, 2, 1);
      issue(2, 'h20, 2, 0); expect_trap(0, 0, 0, "R3");

      // R4 load/load after snoop; none without snoop
      do_reset(); cur_req = "R4";
      issue(9, 'h30, 0, 0);
      g_sv = 1; g_saddr = 'h34; tick();
      issue(8, 'h30, 0, 0); expect_trap(1, 2, 9, "R4");
      do_reset();
      issue(9, 'h30, 0, 0);
      issue(8, 'h30, 0, 0); expect_trap(0, 0, 0, "R4");

      // R12 snoop block granularity
      do_reset(); cur_req = "R12";
      issue(9, 'h30, 0, 0);
      g_sv = 1; g_saddr = 'h38; tick();
      issue(8, 'h30, 0, 0); expect_trap(0, 0, 0, "R12");
      g_sv = 1; g_saddr = 'h37; tick();
      issue(7, 'h30, 3, 0); expect_trap(1, 2, 8, "R12");

      // R5 load after outstanding miss, cleared miss no trap
      do_reset(); cur_req = "R5";
      issue(1, 'h40, 2, 0);
      g_msv = 1; g_msseq = 1; tick();
      issue(2, 'h42, 1, 0); expect_trap(1, 3, 2, "R5");
      do_reset();
      issue(1, 'h40, 2, 0);
      g_msv = 1; g_msseq = 1; tick();
      g_mcv = 1; g_mcseq = 1; tick();
      issue(2, 'h42, 1, 0); expect_trap(0, 0, 0, "R5");

      // R6 aligned range overlap
      do_reset(); cur_req = "R6";
      issue(1, 'h55, 0, 1);
      issue(2, 'h50, 3, 0); expect_trap(1, 1, 2, "R6");
      do_reset();
      issue(1, 'h54, 0, 1);
      issue(2, 'h56, 1, 0); expect_trap(0, 0, 0, "R6");

      // R7 oldest restart wins, ties by kind order
      do_reset(); cur_req = "R7";
      issue(1, 'h60, 0, 1);
      issue(6, 'h60, 0, 0);
      g_sv = 1; g_saddr = 'h60; tick();
      issue(3, 'h60, 1, 0); expect_trap(1, 1, 3, "R7");
      do_reset();
      issue(1, 'h70, 0, 1);
      issue(2, 'h72, 0, 0);
      g_msv = 1; g_msseq = 2; tick();
      issue(3, 'h70, 2, 0); expect_trap(1, 1, 3, "R7");
      do_reset();
      issue(8, 'h80, 0, 0);
      issue(7, 'h81, 0, 0);
      issue(6, 'h80, 1, 1); expect_trap(1, 0, 7, "R7");

      // R10 retire removes entry
      do_reset(); cur_req = "R10";
      issue(5, 'h90, 0, 0);
      g_rv = 1; g_rseq = 5; tick();
      issue(4, 'h90, 0, 1); expect_trap(0, 0, 0, "R10");

      // R11 wrap-bit ordering
      do_reset(); cur_req = "R11";
      issue(17, 'hA0, 0, 0);
      issue(14, 'hA0, 0, 1); expect_trap(1, 0, 17, "R11");
      do_reset();
      issue(33, 'hA0, 0, 0);
      issue(30, 'hA0, 0, 1); expect_trap(1, 0, 1, "R11");
      do_reset();
      issue(30, 'hA0, 0, 0);
      issue(33, 'hA0, 0, 1); expect_trap(0, 0, 0, "R11");

      // random: permuted issue inside blocks of four, model on every clock
      do_reset(); cur_req = "RAND";
      b = 2; pos = 0;
      for (int j = 0; j < 4; j++) perm[j] = j;
      for (int c = 0; c < 3000; c++) begin
         int pend;
         pend = -1;
         if (pos == 0) begin
            for (int j = 3; j > 0; j--) begin
               int r, t;
               r = $urandom_range(j); t = perm[j]; perm[j] = perm[r]; perm[r] = t;
            end
         end
         foreach (mq[i]) if (mq[i].seq < 4 * (b - 1) && (pend < 0 || mq[i].seq < pend)) pend = mq[i].seq;
         if (pend >= 0) begin
            g_rv = 1; g_rseq = pend;
         end else if ($urandom_range(9) < 7) begin
            g_iv = 1; g_iseq = 4 * b + perm[pos]; g_isz = $urandom_range(3);
            g_iaddr = $urandom_range(31) & ~((1 << g_isz) - 1); g_ist = ($urandom_range(2) == 0);
            pos++;
            if (pos == 4) begin pos = 0; b++; end
         end
         if (mq.size() > 0 && $urandom_range(5) == 0) begin
            int ix;
            ix = $urandom_range(mq.size() - 1);
            if (!mq[ix].st) begin g_msv = 1; g_msseq = mq[ix].seq; end
         end
         if (mq.size() > 0 && $urandom_range(7) == 0) begin
            int ix;
            ix = $urandom_range(mq.size() - 1);
            if (mq[ix].miss) begin g_mcv = 1; g_mcseq = mq[ix].seq; end
         end
         if ($urandom_range(5) == 0) begin g_sv = 1; g_saddr = $urandom_range(31); end
         tick();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule